// File: doc/BRIEF.md
# LCD Access Wait-State and Enable Strobe Generator

This block lets a slow character-LCD controller sit directly on a fast 8-bit CPU bus. The bus runs at 4 MHz, so one CPU cycle lasts 250 ns. An unstretched access would hold the LCD enable high for only about 125 ns, which is far below the controller's limits. When the address decode selects the LCD, the block pulls the CPU ready line low for enough cycles to stretch the access to three CPU cycles. The CPU clock keeps running and is never gated. While the access is stretched, the block drives the LCD enable strobe and holds the LCD read/write line steady.

The block runs from a clock at twice the CPU rate, so each CPU cycle has a low half-tick and a high half-tick, and it outputs that phase. The select input is sampled at the end of each low half. An access raises the enable at the start of the first cycle's high half. The enable stays high for five half-ticks (625 ns) and falls at the end of the third cycle's high half. Ready is released one half-tick before the enable falls, so the CPU completes on the third cycle. The controller also needs at least 1200 ns between enable rising edges. If a new select comes too soon, the block adds whole wait cycles, with ready low and no strobe, until ten half-ticks have passed since the previous rising edge.

The states are:
- IDLE: ready high, enable low.
- HOLD: spacing wait, ready low, enable low.
- PULSE: enable high, ready low.
- RELEASE: enable high, ready high.

The transitions are:
- IDLE to PULSE: select is seen and the spacing is already met.
- IDLE to HOLD: select is seen but the spacing is not yet met.
- HOLD to PULSE: the spacing is met at a low-half boundary.
- PULSE to RELEASE: the ready-low ticks have been counted out.
- RELEASE to IDLE: one half-tick later.

Top module: `lcd_wait_gen`

## Requirements
- R1: A synchronous reset sets cpu_rdy to 1, lcd_en to 0 and phase_hi to 0, including when the reset lands in the middle of an access.
- R2: Out of reset, phase_hi alternates on every clock: 0 for the low half-tick and 1 for the high half-tick of each CPU cycle, beginning with 0.
- R3: While lcd_sel is 0 at every low-half sample, cpu_rdy stays 1 and lcd_en stays 0.
- R4: An access that may start immediately raises lcd_en on the clock that ends the low half in which lcd_sel was sampled as 1. lcd_en then stays high for exactly 2×STRETCH_CYC−1 = 5 clocks.
- R5: An immediate access drives cpu_rdy low on the same clock that lcd_en rises, holds it low for exactly 2×(STRETCH_CYC−1) = 4 clocks, and releases it one clock before lcd_en falls.
- R6: Rising edges of lcd_en are at least GAP_TICKS = 10 clocks apart. A select that arrives earlier holds cpu_rdy low, with lcd_en low, until a low-half boundary at which the spacing is met. The pulse then starts there. Expected cpu_rdy-low runs are 8 clocks for back-to-back accesses, 6 clocks with one idle CPU cycle between accesses, and 4 clocks with two idle CPU cycles between accesses.
- R7: lcd_rw takes the value of cpu_rnw on the clock that lcd_en rises and keeps it until the next access starts (1 = read). Its reset value is 1.
- R8: lcd_en never rises unless lcd_sel was 1 at the deciding low-half sample or an access was already waiting in HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the CPU rate |
| rst | input | 1 | Synchronous active-high reset |
| lcd_sel | input | 1 | Address decode for the LCD, held by the CPU while it is stalled |
| cpu_rnw | input | 1 | CPU read/write, 1 = read |
| phase_hi | output | 1 | 1 during the high half of each CPU cycle |
| cpu_rdy | output | 1 | CPU ready; 0 stretches the current cycle |
| lcd_en | output | 1 | LCD enable strobe |
| lcd_rw | output | 1 | LCD read/write, latched at the start of each access |

## Verification
The bench runs accesses back-to-back, with one idle cycle between them, with two idle cycles between them, and as isolated accesses. It measures the rising-edge spacing and the ready-low run in each case. A design that ignores the spacing rule would show a gap of 6 instead of 10. A design that counts the wait in ticks rather than whole cycles would give odd run lengths or a strobe that starts mid-cycle. The bench checks the strobe width against an off-by-one that would give 4 or 6 ticks. It also checks that ready is released exactly one tick before the strobe falls, since releasing it a cycle late would add a fourth CPU cycle. A reset in the middle of an access must drop the strobe at once. Long runs with select held low must never produce a pulse.

// File: rtl/lcd_ws_pkg.sv
package lcd_ws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_PULSE   = 2'd2,
        ST_RELEASE = 2'd3
    } ws_state_e;
endpackage

// File: rtl/lcd_ws_phase.sv
module lcd_ws_phase (
    input  logic clk,
    input  logic rst,
    output logic ph_high
);
    always_ff @(posedge clk) begin
        if (rst) ph_high <= 1'b0;
        else     ph_high <= ~ph_high;
    end

    p_phase_alt_r2: assert property (@(posedge clk) disable iff (rst)
        ph_high |=> !ph_high);
    p_phase_alt2_r2: assert property (@(posedge clk) disable iff (rst)
        !ph_high |=> ph_high);
endmodule

// File: rtl/lcd_ws_gap_timer.sv
module lcd_ws_gap_timer #(
    parameter int GAP_TICKS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_now,
    output logic gap_met
);
    localparam int CW = $clog2(GAP_TICKS + 1);

    logic [CW-1:0] since_q;

    always_ff @(posedge clk) begin
        if (rst)
            since_q <= CW'(GAP_TICKS);
        else if (rise_now)
            since_q <= CW'(1);
        else if (since_q < CW'(GAP_TICKS))
            since_q <= since_q + CW'(1);
    end

    assign gap_met = (since_q >= CW'(GAP_TICKS));

    // R6: a strobe may only start once the spacing counter has run out
    p_rise_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        rise_now |-> gap_met);
endmodule

// File: rtl/lcd_ws_fsm.sv
module lcd_ws_fsm
    import lcd_ws_pkg::*;
#(
    parameter int STRETCH_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ph_high,
    input  logic sel,
    input  logic rnw,
    input  logic gap_met,
    output logic rdy,
    output logic en,
    output logic rw,
    output logic rise_now
);
    localparam int RDY_TICKS = 2 * (STRETCH_CYC - 1);
    localparam int EN_TICKS  = 2 * STRETCH_CYC - 1;
    localparam int TW        = $clog2(RDY_TICKS + 1);
    localparam int RW_W      = $clog2(EN_TICKS + 2);

    ws_state_e     state_q, state_d;
    logic [TW-1:0] tick_q, tick_d;
    logic          decide;

    // the edge that ends a low half is where the select is judged
    assign decide = ~ph_high;

    always_comb begin
        state_d = state_q;
        tick_d  = tick_q;
        unique case (state_q)
            ST_IDLE: begin
                if (decide && sel) begin
                    tick_d  = '0;
                    state_d = gap_met ? ST_PULSE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (decide && gap_met) begin
                    tick_d  = '0;
                    state_d = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (tick_q == TW'(RDY_TICKS - 1)) state_d = ST_RELEASE;
                else                              tick_d  = tick_q + TW'(1);
            end
            ST_RELEASE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign rise_now = (state_d == ST_PULSE) && (state_q != ST_PULSE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tick_q  <= '0;
        end else begin
            state_q <= state_d;
            tick_q  <= tick_d;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy <= 1'b1;
            en  <= 1'b0;
            rw  <= 1'b1;
        end else begin
            rdy <= !((state_d == ST_HOLD) || (state_d == ST_PULSE));
            en  <= (state_d == ST_PULSE) || (state_d == ST_RELEASE);
            if (rise_now) rw <= rnw;
        end
    end

    // checker-only run counter for the strobe width
    logic [RW_W-1:0] en_run_q;
    always_ff @(posedge clk) begin
        if (rst)                          en_run_q <= '0;
        else if (!en)                     en_run_q <= '0;
        else if (en_run_q != '1)          en_run_q <= en_run_q + RW_W'(1);
    end

    p_en_width_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(en) && !$past(rst)) |-> (en_run_q == RW_W'(EN_TICKS)));
    p_rdy_low_at_rise_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(en) |-> !rdy);
    p_rdy_back_before_fall_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(en) && !$past(rst)) |-> $past(rdy));
    p_rw_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en)) |-> $stable(rw));
endmodule

// File: rtl/lcd_wait_gen.sv
module lcd_wait_gen #(
    parameter int STRETCH_CYC = 3,
    parameter int GAP_TICKS   = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic lcd_sel,
    input  logic cpu_rnw,
    output logic phase_hi,
    output logic cpu_rdy,
    output logic lcd_en,
    output logic lcd_rw
);
    logic gap_met;
    logic rise_now;

    lcd_ws_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .ph_high (phase_hi)
    );

    lcd_ws_gap_timer #(.GAP_TICKS(GAP_TICKS)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .rise_now (rise_now),
        .gap_met  (gap_met)
    );

    lcd_ws_fsm #(.STRETCH_CYC(STRETCH_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ph_high  (phase_hi),
        .sel      (lcd_sel),
        .rnw      (cpu_rnw),
        .gap_met  (gap_met),
        .rdy      (cpu_rdy),
        .en       (lcd_en),
        .rw       (lcd_rw),
        .rise_now (rise_now)
    );

    logic hold_seen_q;
    always_ff @(posedge clk) begin
        if (rst) hold_seen_q <= 1'b0;
        else     hold_seen_q <= !cpu_rdy && !lcd_en;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (cpu_rdy && !lcd_en && !phase_hi));
    p_en_needs_sel_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(lcd_en) && !$past(rst)) |-> ($past(lcd_sel) || hold_seen_q));
    p_quiet_when_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!lcd_sel && cpu_rdy && !lcd_en && !phase_hi) |=> !lcd_en);
endmodule

// File: tb/sim_lcd_wait_gen.sv
`timescale 1ns/1ps
module sim_lcd_wait_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lcd_sel = 1'b0;
    logic cpu_rnw = 1'b1;
    logic phase_hi, cpu_rdy, lcd_en, lcd_rw;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    lcd_wait_gen u0 (
        .clk(clk), .rst(rst), .lcd_sel(lcd_sel), .cpu_rnw(cpu_rnw),
        .phase_hi(phase_hi), .cpu_rdy(cpu_rdy), .lcd_en(lcd_en), .lcd_rw(lcd_rw)
    );

    localparam int EXP_EN   = 5;
    localparam int EXP_RDY  = 4;
    localparam int EXP_GAP  = 10;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    int  t = 0;
    int  last_rise = -100;
    int  en_left = 0, rdy_left = 0;
    bit  waiting = 0;
    bit  m_ph = 0, m_en = 0, m_rdy = 1, m_rw = 1;
    bit  model_ok = 0;

    always @(posedge clk) begin
        t++;
        if (rst) begin
            m_ph = 0; m_en = 0; m_rdy = 1; m_rw = 1;
            en_left = 0; rdy_left = 0; waiting = 0; last_rise = t - 100;
        end else begin
            if (en_left > 0) begin
                en_left--;
                if (en_left == 0) m_en = 0;
                if (rdy_left > 0) begin
                    rdy_left--;
                    if (rdy_left == 0) m_rdy = 1;
                end
            end else if (!m_ph && (waiting || lcd_sel)) begin
                if (t - last_rise >= EXP_GAP) begin
                    m_en = 1; en_left = EXP_EN; rdy_left = EXP_RDY;
                    m_rdy = 0; m_rw = cpu_rnw; last_rise = t; waiting = 0;
                end else begin
                    waiting = 1; m_rdy = 0;
                end
            end
            m_ph = !m_ph;
        end
        model_ok = 1;
    end

    // per-clock comparison and edge measurements
    int nt = 0;
    bit p_en = 0, p_rdy = 1;
    int rise_t = -1000, fall_rdy_t = 0;
    int last_gap = 0, last_width = 0, last_run = 0, pulses = 0;

    always @(negedge clk) begin
        nt++;
        if (model_ok) begin
            chk(phase_hi == m_ph, "R2 phase", phase_hi, m_ph);
            chk(lcd_en == m_en, "R4/R6 enable", lcd_en, m_en);
            chk(cpu_rdy == m_rdy, "R5/R6 ready", cpu_rdy, m_rdy);
            chk(lcd_rw == m_rw, "R7 rw", lcd_rw, m_rw);
        end
        if (lcd_en && !p_en) begin
            last_gap = nt - rise_t; rise_t = nt; pulses++;
        end
        if (!lcd_en && p_en) last_width = nt - rise_t;
        if (!cpu_rdy && p_rdy) fall_rdy_t = nt;
        if (cpu_rdy && !p_rdy) last_run = nt - fall_rdy_t;
        p_en = lcd_en; p_rdy = cpu_rdy;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // one CPU cycle; repeats while ready is low at the end of the high half
    task automatic cpu_cycle(input bit s, input bit r);
        @(negedge clk);
        while (phase_hi != 1'b0) @(negedge clk);
        lcd_sel = s; cpu_rnw = r;
        forever begin
            @(negedge clk);
            if (phase_hi && cpu_rdy) break;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cpu_cycle(1'b0, 1'b1);
    endtask

    initial begin
        int p0;
        bit rdy_dropped;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(cpu_rdy == 1, "R1 rdy in reset", cpu_rdy, 1);
        chk(lcd_en == 0, "R1 en in reset", lcd_en, 0);
        chk(phase_hi == 0, "R1 phase in reset", phase_hi, 0);
        chk(lcd_rw == 1, "R7 rw reset", lcd_rw, 1);
        rst = 1'b0;

        // R3 / R8: idle cycles make no strobe and no wait
        p0 = pulses;
        rdy_dropped = 0;
        for (int i = 0; i < 8; i++) begin
            cpu_cycle(1'b0, 1'b0);
            if (!cpu_rdy) rdy_dropped = 1;
        end
        chk(pulses == p0, "R3 no pulse while unselected", pulses, p0);
        chk(rdy_dropped == 0, "R8 ready untouched", rdy_dropped, 0);

        // R4 / R5 / R7: isolated write
        cpu_cycle(1'b1, 1'b0);
        chk(lcd_rw == 0, "R7 rw write", lcd_rw, 0);
        idle(3);
        chk(last_width == EXP_EN, "R4 width isolated", last_width, EXP_EN);
        chk(last_run == EXP_RDY, "R5 ready run isolated", last_run, EXP_RDY);

        // R6: back-to-back
        cpu_cycle(1'b1, 1'b1);
        cpu_cycle(1'b1, 1'b1);
        idle(3);
        chk(last_gap == EXP_GAP, "R6 gap back-to-back", last_gap, EXP_GAP);
        chk(last_run == 8, "R6 ready run back-to-back", last_run, 8);
        chk(last_width == EXP_EN, "R4 width after wait", last_width, EXP_EN);
        chk(lcd_rw == 1, "R7 rw read", lcd_rw, 1);

        // R6: one idle cycle between
        cpu_cycle(1'b1, 1'b0);
        idle(1);
        cpu_cycle(1'b1, 1'b0);
        idle(3);
        chk(last_gap == EXP_GAP, "R6 gap one idle", last_gap, EXP_GAP);
        chk(last_run == 6, "R6 ready run one idle", last_run, 6);

        // R6: two idle cycles between, no wait needed
        cpu_cycle(1'b1, 1'b1);
        idle(2);
        cpu_cycle(1'b1, 1'b1);
        idle(3);
        chk(last_gap == EXP_GAP, "R6 gap two idle", last_gap, EXP_GAP);
        chk(last_run == EXP_RDY, "R6 ready run two idle", last_run, EXP_RDY);

        // R1: reset in the middle of an access
        @(negedge clk);
        while (phase_hi != 1'b0) @(negedge clk);
        lcd_sel = 1'b1; cpu_rnw = 1'b0;
        repeat (3) @(negedge clk);
        chk(lcd_en == 1, "R4 en mid access", lcd_en, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(lcd_en == 0, "R1 en after mid reset", lcd_en, 0);
        chk(cpu_rdy == 1, "R1 rdy after mid reset", cpu_rdy, 1);
        lcd_sel = 1'b0;
        rst = 1'b0;
        idle(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule